// File: doc/BRIEF.md
# Framed RGB-to-Grayscale Stream Converter

This block sits between a byte-wide receive stream and a frame-buffer writer. It scans the incoming bytes for a start marker (0xFF). After that marker it takes the bytes in groups of three: red, then green, then blue. Each group becomes one 7-bit grayscale pixel equal to the integer mean of the three samples. An end marker (0xF1) closes the frame and sets a last flag on the final pixel. Colour samples are 7-bit values (0..127), so neither marker can occur as data.

A completed pixel is held inside the block until the next byte in the frame is accepted. That byte tells the block whether the held pixel is the last one of the frame. Both sides use valid/ready handshakes. The input is stalled while a pixel waits for the downstream side to accept it. The division by three is exact for every sum from 0 to 381 and uses only a constant multiply and a shift.

Top module: `rgb2gray_stream`

## Requirements
- R1: Bytes accepted while hunting (after reset or after an end marker) other than 0xFF are discarded and produce no output pixel.
- R2: An accepted 0xFF enters the frame; the following data bytes are grouped in order red, green, blue, one group per pixel.
- R3: Each output pixel equals floor((R+G+B)/3) exactly for every sum from 0 to 381.
- R4: A completed pixel appears on the output (valid high) in the cycle after the next in-frame byte is accepted, whether that byte is data or 0xF1. Completing a triplet alone produces no output.
- R5: When 0xF1 arrives on a triplet boundary, the held pixel is emitted with last=1. Pixels followed by data are emitted with last=0.
- R6: When 0xF1 arrives mid-triplet, the partial triplet is discarded and the last flag is set on the next pixel emitted.
- R7: A 0xFF accepted inside a frame restarts it: the partial triplet and any held, unsent pixel are discarded. A pending last flag from R6 is kept.
- R8: While the output is valid and not ready, the data and last outputs hold steady and input ready is low.
- R9: After 0xF1 the block hunts again; data bytes and stray 0xF1 bytes are ignored until the next 0xFF.
- R10: During reset, the output is not valid and input ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_data_i | input | 8 | Received byte (marker or colour sample) |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can accept a byte |
| pix_data_o | output | 7 | Grayscale pixel |
| pix_valid_o | output | 1 | Pixel valid |
| pix_last_o | output | 1 | Final pixel of a frame |
| pix_ready_i | input | 1 | Downstream accepts the pixel |

## Verification
A pixel becomes visible one cycle after the handshake of the byte that follows its blue sample. It is never visible right after the blue sample itself. The bench therefore checks the output one time unit after the rising edge that accepted the byte under test, and checks at the same point after a blue byte that nothing is yet valid. A separate monitor logs pixels at each falling edge where valid and ready are both high, so each is counted exactly once. The per-scenario tasks compare that log against expected data and last flags, computed in the bench from the colour bytes sent. During backpressure the outputs are sampled over several falling edges to confirm they hold steady.

// File: rtl/gray_pkg.sv
package gray_pkg;
  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_FRAME = 1'b1
  } gray_state_e;

  localparam logic [7:0] START_MARK = 8'hFF;
  localparam logic [7:0] END_MARK   = 8'hF1;
endpackage

// File: rtl/gray_div3.sv
module gray_div3 #(
  parameter int SUM_W = 9,
  parameter int Q_W   = 7
) (
  input  logic [SUM_W-1:0] sum_i,
  output logic [Q_W-1:0]   q_o
);
  // floor(s/3) == (s*171)>>9 for s <= 381 (error stays below 1/3)
  localparam int SHIFT  = 9;
  localparam int MUL    = 171;
  localparam int PROD_W = SUM_W + 8;

  assign q_o = Q_W'((PROD_W'(sum_i) * PROD_W'(MUL)) >> SHIFT);
endmodule

// File: rtl/gray_frame_ctrl.sv
module gray_frame_ctrl
  import gray_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PIX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              take_i,
  output logic              emit_o,
  output logic [PIX_W-1:0]  emit_pix_o,
  output logic              emit_last_o
);
  localparam int SUM_W = PIX_W + 2;

  gray_state_e        state_q;
  logic [1:0]         lane_q;
  logic [SUM_W-1:0]   sum_q;
  logic [PIX_W-1:0]   held_q;
  logic               held_v_q;
  logic               pend_q;
  logic [SUM_W-1:0]   total;
  logic [PIX_W-1:0]   quot;
  logic               is_start, is_end, in_frame, data_take;

  assign is_start  = (byte_i == START_MARK);
  assign is_end    = (byte_i == END_MARK);
  assign in_frame  = (state_q == ST_FRAME);
  assign data_take = take_i && in_frame && !is_start && !is_end;
  assign total     = sum_q + SUM_W'(byte_i);

  gray_div3 #(.SUM_W(SUM_W), .Q_W(PIX_W)) u_div (
    .sum_i (total),
    .q_o   (quot)
  );

  // held pixel leaves when the following in-frame byte (data or end) arrives
  assign emit_o      = take_i && in_frame && !is_start && held_v_q && (lane_q == 2'd0);
  assign emit_pix_o  = held_q;
  assign emit_last_o = is_end || pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      lane_q   <= 2'd0;
      sum_q    <= '0;
      held_q   <= '0;
      held_v_q <= 1'b0;
      pend_q   <= 1'b0;
    end else if (take_i) begin
      if (is_start) begin
        state_q  <= ST_FRAME;
        lane_q   <= 2'd0;
        sum_q    <= '0;
        held_v_q <= 1'b0;
      end else if (in_frame && is_end) begin
        state_q  <= ST_HUNT;
        lane_q   <= 2'd0;
        sum_q    <= '0;
        held_v_q <= 1'b0;
        if (lane_q != 2'd0) pend_q <= 1'b1;
        else if (held_v_q)  pend_q <= 1'b0;
      end else if (in_frame) begin
        if (lane_q == 2'd0 && held_v_q) begin
          held_v_q <= 1'b0;
          pend_q   <= 1'b0;
        end
        if (lane_q == 2'd2) begin
          held_q   <= quot;
          held_v_q <= 1'b1;
          lane_q   <= 2'd0;
          sum_q    <= '0;
        end else begin
          lane_q <= lane_q + 2'd1;
          sum_q  <= total;
        end
      end
    end
  end

  assert_lane_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_q != 2'd3);

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && is_start) |=> (state_q == ST_FRAME && lane_q == 2'd0 && !held_v_q));

  assert_exact_div_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_take && lane_q == 2'd2) |=>
      (held_v_q && (SUM_W'(held_q) * SUM_W'(3) <= $past(total))
                && ($past(total) < SUM_W'(held_q) * SUM_W'(3) + SUM_W'(3))));

  assert_hunt_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) |-> !held_v_q);
endmodule

// File: rtl/gray_out_stage.sv
module gray_out_stage #(
  parameter int PIX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             last_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pix_o   <= '0;
      last_o  <= 1'b0;
    end else if (emit_i) begin
      valid_o <= 1'b1;
      pix_o   <= pix_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(pix_o) && $stable(last_o)));

  assert_emit_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i |-> !valid_o);
endmodule

// File: rtl/rgb2gray_stream.sv
module rgb2gray_stream #(
  parameter int BYTE_W = 8,
  parameter int PIX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [PIX_W-1:0]  pix_data_o,
  output logic              pix_valid_o,
  output logic              pix_last_o,
  input  logic              pix_ready_i
);
  logic             take;
  logic             emit;
  logic [PIX_W-1:0] emit_pix;
  logic             emit_last;

  assign in_ready_o = !pix_valid_o;
  assign take       = in_valid_i && in_ready_o;

  gray_frame_ctrl #(.BYTE_W(BYTE_W), .PIX_W(PIX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_i      (in_data_i),
    .take_i      (take),
    .emit_o      (emit),
    .emit_pix_o  (emit_pix),
    .emit_last_o (emit_last)
  );

  gray_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .emit_i  (emit),
    .pix_i   (emit_pix),
    .last_i  (emit_last),
    .ready_i (pix_ready_i),
    .valid_o (pix_valid_o),
    .pix_o   (pix_data_o),
    .last_o  (pix_last_o)
  );

  assert_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i) |=> !in_ready_o);
endmodule

// File: tb/sim_rgb2gray_stream.sv
module sim_rgb2gray_stream;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [6:0] pix_data;
  logic       pix_valid;
  logic       pix_last;
  logic       pix_ready = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [6:0] got_d [0:511];
  logic       got_l [0:511];
  int         got_n = 0;
  logic [6:0] exp_d [0:511];
  logic       exp_l [0:511];
  int         exp_n = 0;

  always #2 clk = ~clk;

  rgb2gray_stream u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_data_i   (in_data),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .pix_data_o  (pix_data),
    .pix_valid_o (pix_valid),
    .pix_last_o  (pix_last),
    .pix_ready_i (pix_ready)
  );

  // monitor: log each accepted pixel once
  always begin
    @(negedge clk);
    #1;
    if (rst_n && pix_valid && pix_ready && got_n < 512) begin
      got_d[got_n] = pix_data;
      got_l[got_n] = pix_last;
      got_n = got_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic send_rgb(input int r, input int g, input int b);
    send_byte(8'(r));
    send_byte(8'(g));
    send_byte(8'(b));
  endtask

  task automatic clear_log();
    repeat (4) @(negedge clk);
    got_n = 0;
    exp_n = 0;
  endtask

  task automatic push_exp(input int d, input bit l);
    exp_d[exp_n] = 7'(d);
    exp_l[exp_n] = l;
    exp_n++;
  endtask

  task automatic compare_log(input string tag);
    repeat (4) @(negedge clk);
    chk(got_n == exp_n, {tag, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_d[i] == exp_d[i], {tag, " data"}, int'(got_d[i]), int'(exp_d[i]));
      chk(got_l[i] == exp_l[i], {tag, " last"}, int'(got_l[i]), int'(exp_l[i]));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    #1;
    chk(pix_valid == 1'b0, "R10 valid in reset", int'(pix_valid), 0);
    chk(in_ready == 1'b1, "R10 ready in reset", int'(in_ready), 1);
  endtask

  task automatic t_hunt();
    clear_log();
    send_byte(8'd10); send_byte(8'd20); send_byte(8'd30);
    send_byte(8'd40); send_byte(8'd50); send_byte(8'd60);
    send_byte(8'd70);
    compare_log("R1 pre-start bytes");
  endtask

  task automatic t_basic();
    clear_log();
    send_byte(8'hFF);
    send_rgb(1, 2, 3);
    chk(pix_valid == 1'b0, "R4 no output after blue", int'(pix_valid), 0);
    send_byte(8'd127);
    chk(pix_valid == 1'b1, "R4 valid after next byte", int'(pix_valid), 1);
    chk(pix_data == 7'd2, "R4 data after next byte", int'(pix_data), 2);
    send_byte(8'd127); send_byte(8'd127);
    send_rgb(0, 0, 2);
    send_byte(8'hF1);
    push_exp(2, 1'b0); push_exp(127, 1'b0); push_exp(0, 1'b1);
    compare_log("R2 R5 basic frame");
  endtask

  task automatic t_div_sweep();
    clear_log();
    send_byte(8'hFF);
    for (int s = 0; s <= 381; s++) begin
      int r, g, b;
      r = (s > 127) ? 127 : s;
      g = ((s - r) > 127) ? 127 : (s - r);
      b = s - r - g;
      send_rgb(r, g, b);
      push_exp(s / 3, (s == 381));
    end
    send_byte(8'hF1);
    compare_log("R3 sum sweep");
  endtask

  task automatic t_mid_end();
    clear_log();
    send_byte(8'hFF);
    send_rgb(9, 9, 9);
    send_byte(8'd6); send_byte(8'd6);
    send_byte(8'hF1);
    send_byte(8'hFF);
    send_rgb(3, 3, 3);
    send_rgb(12, 12, 12);
    send_byte(8'hF1);
    push_exp(9, 1'b0); push_exp(3, 1'b1); push_exp(12, 1'b1);
    compare_log("R6 end mid-triplet");
  endtask

  task automatic t_restart();
    clear_log();
    send_byte(8'hFF);
    send_rgb(30, 30, 30);
    send_byte(8'hFF);
    send_byte(8'd7); send_byte(8'd8);
    send_byte(8'hFF);
    send_rgb(90, 90, 90);
    send_rgb(45, 45, 46);
    send_byte(8'hF1);
    push_exp(90, 1'b0); push_exp(45, 1'b1);
    compare_log("R7 restart");
  endtask

  task automatic t_after_end();
    clear_log();
    send_byte(8'hFF);
    send_rgb(5, 5, 5);
    send_byte(8'hF1);
    send_rgb(50, 50, 50);
    send_byte(8'hF1);
    send_rgb(60, 60, 60);
    send_byte(8'hFF);
    send_rgb(1, 1, 1);
    send_byte(8'hF1);
    push_exp(5, 1'b1); push_exp(1, 1'b1);
    compare_log("R9 ignore after end");
  endtask

  task automatic t_backpressure();
    clear_log();
    @(negedge clk);
    pix_ready = 1'b0;
    send_byte(8'hFF);
    send_rgb(20, 20, 20);
    send_byte(8'd40);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1;
      chk(pix_valid == 1'b1, "R8 valid held", int'(pix_valid), 1);
      chk(pix_data == 7'd20, "R8 data held", int'(pix_data), 20);
      chk(pix_last == 1'b0, "R8 last held", int'(pix_last), 0);
      chk(in_ready == 1'b0, "R8 input stalled", int'(in_ready), 0);
    end
    @(negedge clk);
    pix_ready = 1'b1;
    send_byte(8'd40); send_byte(8'd40);
    send_byte(8'hF1);
    push_exp(20, 1'b0); push_exp(40, 1'b1);
    compare_log("R8 backpressure");
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_hunt();
    t_basic();
    t_div_sweep();
    t_mid_end();
    t_restart();
    t_after_end();
    t_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule